// File: doc/BRIEF.md
# Auto-Ranging Clock Rate Sequencer

This block drives a gated edge counter that sits elsewhere on the chip. For one clock source it finds the longest gate window that does not saturate the counter. It then reports the source frequency in hertz and the resolution that goes with that window. A client pulses `start` with a source number. The sequencer then runs a series of attempts on a small register bus. Each attempt programs the counter, starts a gated run, polls a busy flag and reads back the edge count.

The search begins with the longest window. Whenever the count saturates, the window shrinks by a fixed step. The first count that fits is converted to a rounded rate. A second division gives the precision. Both divisions run on a shared iterative divider design. When the counter hangs, or when even the shortest window saturates, the run ends with an error flag in place of a rate.

Top module: `msr_autorange`

## Requirements
- R1: The first attempt after a start uses a 640 us gate, which is written as 639 into the duration field (control bits 15:0).
- R2: Each later attempt in the same run uses a gate 32 us shorter than the one before. No gate below 32 us is ever programmed.
- R3: A count of 0xFFFF or more, read from the result register at byte offset 0xC, counts as saturation and starts another attempt. A count of 0xFFFE or less is accepted.
- R4: An accepted count gives `rate_hz` = (count * 1,000,000 + gate/2) / gate, using integer division, so the result is rounded to the nearest hertz.
- R5: With an accepted count, `prec_hz` = 2,000,000 / gate, truncated.
- R6: Each attempt makes four writes to the control register at byte offset 0x4, in this order:
  - zero;
  - the duration field alone;
  - duration plus source (bits 26:20);
  - the same with enable (bit 16) and run (bit 19) set.
- R7: After the counter reports not busy (bit 31 of a control read), the sequencer writes the control word with enable cleared and run kept set. Only after that write does it read the result register.
- R8: If busy is still set after TIMEOUT_CYC polling cycles, the sequencer still makes the enable-clearing write. It then finishes with `err`=1 and `rate_hz`=`prec_hz`=0.
- R9: If the 32 us gate still saturates, the run finishes with `err`=1 and zero rate and precision.
- R10: `done` is high for exactly one cycle per run. The outputs are cleared when a start is accepted and hold their final values from `done` until the next accepted start.
- R11: A `start` pulse while a run is in progress is ignored. The ongoing run keeps its source, its bus traffic and its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Run request, sampled when idle |
| src | input | 7 | Source number to measure |
| done | output | 1 | One-cycle end-of-run pulse |
| err | output | 1 | Run ended by timeout or saturation at the shortest gate |
| rate_hz | output | 32 | Measured frequency in Hz |
| prec_hz | output | 16 | Resolution of the reported rate in Hz |
| bus_wr | output | 1 | Register write strobe |
| bus_rd | output | 1 | Register read strobe |
| bus_addr | output | 4 | Byte offset of the accessed register |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid the cycle after `bus_rd` |

## Verification
The assertions assume the following about the counter. It answers every read exactly one cycle later. It never changes the control word it was given. Its result register holds whatever it counted during the last completed gate. The stub in the bench keeps to these rules: it registers its read data and accepts control writes only from the sequencer. The bench drives `start` only once the previous `done` has passed, apart from one deliberate mid-run pulse. It also scales the gate in cycles and sets a short timeout limit, so that the longest window and a hung counter both fit in a short run.

// File: rtl/msr_pkg.sv
package msr_pkg;

  localparam logic [3:0] CTL_ADDR = 4'h4;
  localparam logic [3:0] CNT_ADDR = 4'hC;

  localparam int DUR_W    = 16;
  localparam int SRC_W    = 7;
  localparam int EN_BIT   = 16;
  localparam int RUN_BIT  = 19;
  localparam int SRC_LSB  = 20;
  localparam int BUSY_BIT = 31;

  localparam logic [31:0] CNT_SAT = 32'h0000_FFFF;

  typedef enum logic [3:0] {
    S_IDLE, S_CLR, S_DUR, S_SRC, S_GO, S_POLL, S_CHK,
    S_DIS, S_RDCNT, S_CHKCNT, S_DIV
  } seq_state_e;

  function automatic logic [31:0] ctl_word(input logic [DUR_W-1:0] dur,
                                           input logic [SRC_W-1:0] srcn,
                                           input logic en,
                                           input logic run);
    logic [31:0] w;
    w = 32'd0;
    w[DUR_W-1:0] = dur;
    w[SRC_LSB +: SRC_W] = srcn;
    w[EN_BIT] = en;
    w[RUN_BIT] = run;
    return w;
  endfunction

  function automatic logic is_saturated(input logic [31:0] cnt);
    return cnt >= CNT_SAT;
  endfunction

endpackage

// File: rtl/msr_div.sv
module msr_div #(
  parameter int NUM_W = 36,
  parameter int DEN_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             done,
  output logic [NUM_W-1:0] quot
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [DEN_W-1:0] rem_q;
  logic [DEN_W-1:0] den_q;
  logic [NUM_W-1:0] q_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic [DEN_W:0]   trial;
  logic             fits;

  assign trial = {rem_q, q_q[NUM_W-1]};
  assign fits  = trial >= {1'b0, den_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      den_q <= '0;
      q_q   <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem_q <= '0;
        den_q <= den;
        q_q   <= num;
        cnt_q <= CNT_W'(NUM_W);
        run_q <= 1'b1;
      end else if (run_q) begin
        if (fits) rem_q <= DEN_W'(trial - {1'b0, den_q});
        else      rem_q <= trial[DEN_W-1:0];
        q_q   <= {q_q[NUM_W-2:0], fits};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          run_q <= 1'b0;
          done  <= 1'b1;
        end
      end
    end
  end

  assign quot = q_q;
endmodule

// File: rtl/msr_gate_step.sv
module msr_gate_step #(
  parameter int GATE_MAX_US  = 640,
  parameter int GATE_STEP_US = 32,
  parameter int GATE_MIN_US  = 32,
  parameter int GATE_W       = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  output logic [GATE_W-1:0] gate,
  output logic              at_floor
);
  localparam logic [GATE_W-1:0] G_MAX  = GATE_W'(GATE_MAX_US);
  localparam logic [GATE_W-1:0] G_STEP = GATE_W'(GATE_STEP_US);
  localparam logic [GATE_W:0]   G_NEXT_MIN = (GATE_W+1)'(GATE_MIN_US + GATE_STEP_US);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     gate <= G_MAX;
    else if (load)  gate <= G_MAX;
    else if (step)  gate <= gate - G_STEP;
  end

  assign at_floor = {1'b0, gate} < G_NEXT_MIN;
endmodule

// File: rtl/msr_watch.sv
module msr_watch #(
  parameter int LIMIT = 1250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         cnt_q <= '0;
    else if (clr)                       cnt_q <= '0;
    else if (run && (cnt_q != LAST))    cnt_q <= cnt_q + 1'b1;
  end

  assign expired = cnt_q == LAST;
endmodule

// File: rtl/msr_autorange.sv
module msr_autorange
  import msr_pkg::*;
#(
  parameter int GATE_MAX_US  = 640,
  parameter int GATE_STEP_US = 32,
  parameter int GATE_MIN_US  = 32,
  parameter int TIMEOUT_CYC  = 1250000,
  parameter int RATE_W       = 32,
  parameter int PREC_W       = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [6:0]        src,
  output logic              done,
  output logic              err,
  output logic [RATE_W-1:0] rate_hz,
  output logic [PREC_W-1:0] prec_hz,
  output logic              bus_wr,
  output logic              bus_rd,
  output logic [3:0]        bus_addr,
  output logic [31:0]       bus_wdata,
  input  logic [31:0]       bus_rdata
);
  localparam int GATE_W  = $clog2(GATE_MAX_US + 1);
  localparam int SCALE_W = 21;
  localparam int NUM_W   = DUR_W + SCALE_W;
  localparam longint ONE_MEG = 1000000;
  localparam longint TWO_MEG = 2000000;

  seq_state_e        state;
  logic [SRC_W-1:0]  src_q;
  logic              tmo_hit;
  logic [GATE_W-1:0] gate;
  logic              at_floor;
  logic              tmo_exp;
  logic [DUR_W-1:0]  dur_field;
  logic              div_go;
  logic              rate_done;
  logic              prec_done;
  logic [NUM_W-1:0]  rate_q;
  logic [NUM_W-1:0]  prec_q;
  logic [NUM_W-1:0]  rate_num;

  // named events used by the checker
  logic ev_start;
  logic ev_overflow;
  logic ev_timeout;
  logic ev_retry;

  function automatic logic [NUM_W-1:0] f_rate_num(input logic [31:0] cnt,
                                                  input logic [GATE_W-1:0] g);
    return NUM_W'(cnt[DUR_W-1:0]) * NUM_W'(ONE_MEG) + NUM_W'(g >> 1);
  endfunction

  assign dur_field   = DUR_W'(gate) - 1'b1;
  assign ev_start    = start && (state == S_IDLE);
  assign ev_overflow = (state == S_CHKCNT) && is_saturated(bus_rdata);
  assign ev_retry    = ev_overflow && !at_floor;
  assign ev_timeout  = (state == S_CHK) && bus_rdata[BUSY_BIT] && tmo_exp;
  assign div_go      = (state == S_CHKCNT) && !is_saturated(bus_rdata);
  assign rate_num    = f_rate_num(bus_rdata, gate);

  msr_gate_step #(
    .GATE_MAX_US(GATE_MAX_US), .GATE_STEP_US(GATE_STEP_US),
    .GATE_MIN_US(GATE_MIN_US), .GATE_W(GATE_W)
  ) u_gate (
    .clk(clk), .rst_n(rst_n), .load(ev_start), .step(ev_retry),
    .gate(gate), .at_floor(at_floor)
  );

  msr_watch #(.LIMIT(TIMEOUT_CYC)) u_watch (
    .clk(clk), .rst_n(rst_n), .clr(state == S_GO),
    .run((state == S_POLL) || (state == S_CHK)), .expired(tmo_exp)
  );

  msr_div #(.NUM_W(NUM_W), .DEN_W(GATE_W)) u_rate_div (
    .clk(clk), .rst_n(rst_n), .start(div_go), .num(rate_num),
    .den(gate), .done(rate_done), .quot(rate_q)
  );

  msr_div #(.NUM_W(NUM_W), .DEN_W(GATE_W)) u_prec_div (
    .clk(clk), .rst_n(rst_n), .start(div_go), .num(NUM_W'(TWO_MEG)),
    .den(gate), .done(prec_done), .quot(prec_q)
  );

  // bus drive decoded from state
  always_comb begin
    bus_wr    = 1'b0;
    bus_rd    = 1'b0;
    bus_addr  = CTL_ADDR;
    bus_wdata = 32'd0;
    unique case (state)
      S_CLR:   bus_wr = 1'b1;
      S_DUR:   begin bus_wr = 1'b1; bus_wdata = ctl_word(dur_field, '0, 1'b0, 1'b0); end
      S_SRC:   begin bus_wr = 1'b1; bus_wdata = ctl_word(dur_field, src_q, 1'b0, 1'b0); end
      S_GO:    begin bus_wr = 1'b1; bus_wdata = ctl_word(dur_field, src_q, 1'b1, 1'b1); end
      S_POLL:  bus_rd = 1'b1;
      S_DIS:   begin bus_wr = 1'b1; bus_wdata = ctl_word(dur_field, src_q, 1'b0, 1'b1); end
      S_RDCNT: begin bus_rd = 1'b1; bus_addr = CNT_ADDR; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      src_q   <= '0;
      tmo_hit <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
      rate_hz <= '0;
      prec_hz <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          src_q   <= src;
          tmo_hit <= 1'b0;
          err     <= 1'b0;
          rate_hz <= '0;
          prec_hz <= '0;
          state   <= S_CLR;
        end
        S_CLR:  state <= S_DUR;
        S_DUR:  state <= S_SRC;
        S_SRC:  state <= S_GO;
        S_GO:   state <= S_POLL;
        S_POLL: state <= S_CHK;
        S_CHK: begin
          if (!bus_rdata[BUSY_BIT]) state <= S_DIS;
          else if (tmo_exp) begin
            tmo_hit <= 1'b1;
            state   <= S_DIS;
          end else state <= S_POLL;
        end
        S_DIS: begin
          if (tmo_hit) begin
            err   <= 1'b1;
            done  <= 1'b1;
            state <= S_IDLE;
          end else state <= S_RDCNT;
        end
        S_RDCNT: state <= S_CHKCNT;
        S_CHKCNT: begin
          if (ev_overflow) begin
            if (at_floor) begin
              err   <= 1'b1;
              done  <= 1'b1;
              state <= S_IDLE;
            end else state <= S_CLR;
          end else state <= S_DIV;
        end
        S_DIV: if (rate_done && prec_done) begin
          rate_hz <= rate_q[RATE_W-1:0];
          prec_hz <= prec_q[PREC_W-1:0];
          done    <= 1'b1;
          state   <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/msr_autorange_chk.sv
module msr_autorange_chk #(
  parameter int GATE_MAX_US  = 640,
  parameter int GATE_STEP_US = 32,
  parameter int GATE_MIN_US  = 32,
  parameter int RATE_W       = 32,
  parameter int PREC_W       = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done,
  input logic              err,
  input logic [RATE_W-1:0] rate_hz,
  input logic [PREC_W-1:0] prec_hz,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [3:0]        bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              ev_start,
  input logic              ev_overflow,
  input logic              ev_timeout
);
  logic        ctl_wr, go_wr;
  logic        first_pend, seen_zero, last_en, active;
  logic [15:0] last_dur;

  assign ctl_wr = bus_wr && (bus_addr == 4'h4);
  assign go_wr  = ctl_wr && bus_wdata[16] && bus_wdata[19];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_pend <= 1'b0;
      seen_zero  <= 1'b0;
      last_en    <= 1'b0;
      active     <= 1'b0;
      last_dur   <= 16'd0;
    end else begin
      if (ev_start) first_pend <= 1'b1;
      else if (go_wr) first_pend <= 1'b0;
      if (go_wr) seen_zero <= 1'b0;
      else if (ctl_wr && bus_wdata == 32'd0) seen_zero <= 1'b1;
      if (ctl_wr) last_en <= bus_wdata[16];
      if (go_wr) last_dur <= bus_wdata[15:0];
      if (ev_start) active <= 1'b1;
      else if (done) active <= 1'b0;
    end
  end

  assert_first_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    go_wr && first_pend |-> bus_wdata[15:0] == 16'(GATE_MAX_US - 1));

  assert_gate_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    go_wr && !first_pend |-> (bus_wdata[15:0] == last_dur - 16'(GATE_STEP_US))
                             && (int'(bus_wdata[15:0]) + 1 >= GATE_MIN_US));

  assert_retry_after_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_overflow && (int'(last_dur) + 1 > GATE_MIN_US) |=> ctl_wr && bus_wdata == 32'd0);

  assert_prec_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done && !err |-> int'(prec_hz) == 2000000 / (int'(last_dur) + 1));

  assert_clear_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    go_wr |-> seen_zero);

  assert_disable_before_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_addr == 4'hC |-> !last_en);

  assert_timeout_disable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_timeout |=> ctl_wr && !bus_wdata[16]);

  assert_err_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done && err |-> rate_hz == '0 && prec_hz == '0);

  assert_floor_error_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_overflow && (int'(last_dur) + 1 == GATE_MIN_US) |=> done && err);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_no_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |-> !active || done);

  assert_bus_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_rd));
endmodule

bind msr_autorange msr_autorange_chk #(
  .GATE_MAX_US(GATE_MAX_US), .GATE_STEP_US(GATE_STEP_US),
  .GATE_MIN_US(GATE_MIN_US), .RATE_W(RATE_W), .PREC_W(PREC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .err(err),
  .rate_hz(rate_hz), .prec_hz(prec_hz), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .ev_start(ev_start),
  .ev_overflow(ev_overflow), .ev_timeout(ev_timeout)
);

// File: tb/tb_msr_autorange.sv
module tb_msr_autorange;
  localparam int US_CYC = 2;
  localparam int TMO    = 2000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [6:0]  src = '0;
  logic        done, err;
  logic [31:0] rate_hz;
  logic [15:0] prec_hz;
  logic        bus_wr, bus_rd;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata = '0;

  always #4 clk = ~clk;

  msr_autorange #(.TIMEOUT_CYC(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .src(src), .done(done), .err(err),
    .rate_hz(rate_hz), .prec_hz(prec_hz), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural counter stub
  logic [31:0] ctl_r = '0;
  logic [31:0] cnt_r = '0;
  bit          busy_s = 0;
  int          gate_left = 0;
  longint      stub_freq = 0;
  bit          stub_hang = 0;

  always @(posedge clk) begin
    if (bus_wr && bus_addr == 4'h4) begin
      ctl_r <= bus_wdata;
      if (bus_wdata[16] && bus_wdata[19] && !busy_s) begin
        busy_s    <= 1;
        gate_left <= (int'(bus_wdata[15:0]) + 1) * US_CYC;
      end
    end else if (busy_s && !stub_hang) begin
      if (gate_left <= 1) begin
        longint c;
        c = stub_freq * (longint'(ctl_r[15:0]) + 1) / 1000000;
        if (c > 65535) c = 65535;
        cnt_r  <= 32'(c);
        busy_s <= 0;
      end else gate_left <= gate_left - 1;
    end
    if (bus_rd)
      bus_rdata <= (bus_addr == 4'h4) ? {busy_s, ctl_r[30:0]} :
                   (bus_addr == 4'hC) ? cnt_r : 32'd0;
  end

  // reference model
  logic [35:0] exp_q[$];
  bit          active = 0;
  longint      exp_rate = 0, exp_prec = 0, held_rate = 0, held_prec = 0;
  bit          exp_err = 0, held_err = 0;
  bit          tb_end = 0;

  always @(negedge clk) begin
    if (rst_n && !tb_end) begin
      if (bus_rd && bus_addr == 4'hC)
        check(!ctl_r[16], "R7 result read with enable set", ctl_r[16], 0);
      if (bus_wr) begin
        if (exp_q.size() == 0) check(0, "R6 unexpected write", bus_wdata, -1);
        else begin
          logic [35:0] e;
          e = exp_q.pop_front();
          check({bus_addr, bus_wdata} == e, "R1/R2/R6 write word", {bus_addr, bus_wdata}, e);
        end
      end
      if (done) begin
        check(active, "R10 done without run", 0, 1);
        check(rate_hz == 32'(exp_rate), "R4 rate", rate_hz, exp_rate);
        check(prec_hz == 16'(exp_prec), "R5 precision", prec_hz, exp_prec);
        check(err == exp_err, "R8/R9 error flag", err, exp_err);
        check(exp_q.size() == 0, "R3 missing attempts", exp_q.size(), 0);
        held_rate = exp_rate; held_prec = exp_prec; held_err = exp_err;
        active = 0;
      end else if (active) begin
        check(rate_hz == 0 && prec_hz == 0 && err == 0, "R10 outputs cleared during run",
              rate_hz, 0);
      end else begin
        check(rate_hz == 32'(held_rate) && prec_hz == 16'(held_prec) && err == held_err,
              "R10 outputs held", rate_hz, held_rate);
      end
    end
  end

  task automatic run_case(input longint f, input bit hang, input logic [6:0] s, input bit poke);
    longint cnt;
    logic [31:0] dw, sw;
    exp_err = 1; exp_rate = 0; exp_prec = 0;
    for (int g = 640; g >= 32; g -= 32) begin
      dw = 32'(g - 1);
      sw = dw | (32'(s) << 20);
      exp_q.push_back({4'h4, 32'd0});
      exp_q.push_back({4'h4, dw});
      exp_q.push_back({4'h4, sw});
      exp_q.push_back({4'h4, sw | 32'h0009_0000});
      exp_q.push_back({4'h4, sw | 32'h0008_0000});
      if (hang) break;
      cnt = f * g / 1000000;
      if (cnt > 65535) cnt = 65535;
      if (cnt < 65535) begin
        exp_err = 0;
        exp_rate = (cnt * 1000000 + g / 2) / g;
        exp_prec = 2000000 / g;
        break;
      end
    end
    stub_freq = f; stub_hang = hang;
    @(negedge clk); start = 1; src = s;
    @(posedge clk); active = 1;
    @(negedge clk); start = 0; src = 7'd0;
    if (poke) begin
      repeat (60) @(negedge clk);
      start = 1; src = 7'd5;             // R11 pulse mid-run
      @(negedge clk); start = 0;
    end
    wait (active == 0);
    repeat (5) @(negedge clk);
    stub_hang = 0;
    if (busy_s) begin rst_n = 1; end
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 150000) begin
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        tb_end = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(done == 0 && err == 0 && rate_hz == 0 && prec_hz == 0, "R10 reset state", rate_hz, 0);
    rst_n = 1;
    @(negedge clk);
    check(!bus_wr && !bus_rd, "R10 idle bus after reset", bus_wr, 0);
    run_case(64'd1000000,   0, 7'd3,  0);  // R1 R4 R5 first gate fits
    run_case(64'd123456789, 0, 7'd10, 0);  // R2 R3 several retries
    run_case(64'd102398438, 0, 7'd11, 0);  // R3 count exactly 0xFFFF retries
    run_case(64'd102396900, 0, 7'd12, 0);  // R3 count 0xFFFE accepted
    run_case(64'd1600,      0, 7'd13, 0);  // R4 half rounds up
    run_case(64'd0,         0, 7'd14, 0);  // R4 zero rate
    run_case(64'd3000000000, 0, 7'd15, 0); // R9 floor still saturates
    run_case(64'd5000,      1, 7'd127, 0); // R8 counter hangs
    run_case(64'd1500000,   0, 7'd20, 1);  // R11 start ignored mid-run
    repeat (20) @(negedge clk);
    tb_end = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule